// File: doc/BRIEF.md
# Vertical Linear Interpolation Blender

This block stretches a picture vertically. It works in the output pixel clock domain and sits between a pair of line-buffer banks and the output pixel path. One bank holds the even source lines and the other holds the odd source lines. Each bank keeps a small ring of line slots.

At every output line start, a phase accumulator advances by a programmable step. The step is the ratio of source lines to output lines, written as an unsigned integer.fraction number with four fraction bits. The integer part n of the phase names the upper of two adjacent source lines, n and n+1. The fraction w is the blend weight for the whole output line. Because the step is usually below one line, the same source pair serves several output lines, and the weight moves a little on each of them.

For each output pixel strobe, the block sends one read request to both banks at once. Both banks are read at the same column. The bank data arrives one cycle later. The block blends each colour channel with rounding and presents the result one further cycle later with a valid flag. The default configuration covers 1024 pixels per line, 8 slots per bank and 3 channels of 8 bits.

Top module: `vlb_blender`

## Requirements
- R1: While rst_ni is low, pix_vld_o is 0 and pix_o is 0.
- R2: rd_en_o is high in exactly the cycles in which pix_stb_i is high.
- R3: The low X_W bits of both read addresses are the column index. The column is 0 for the first strobe after line_start_i and rises by one with each later strobe. Non-strobe cycles leave it unchanged.
- R4: frame_start_i sets the phase to zero, so the next output line uses position 0. Each later line_start_i advances the phase by the step_i value present in that line_start_i cycle. If frame_start_i and line_start_i are high together, the line uses position 0.
- R5: For integer position n, the even-bank slot is ((n+1)>>1) mod 2^SLOT_W and the odd-bank slot is (n>>1) mod 2^SLOT_W. The slot sits in the address bits above the column field.
- R6: Each channel result is (a*(16-w) + b*w + 8) >> 4. Here w is the 4-bit phase fraction, a is the pixel of source line n and b is the pixel of source line n+1.
- R7: When n is even, a comes from the even bank and b from the odd bank. When n is odd, a comes from the odd bank and b from the even bank.
- R8: With w = 0, the result equals a exactly, for every value of a and b.
- R9: pix_vld_o is high exactly two cycles after a pix_stb_i cycle, and pix_o holds the blend for that strobe. pix_o does not change while pix_vld_o is low.
- R10: Channel c sits in bits [c*CH_W +: CH_W] of every pixel bus. Each channel is blended with no effect on any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Zeroes the vertical phase |
| line_start_i | input | 1 | Output line start; loads the line position and resets the column |
| pix_stb_i | input | 1 | Output pixel strobe |
| step_i | input | INT_W+4 | Source lines per output line, with 4 fraction bits |
| rd_en_o | output | 1 | Read request to both banks |
| rd_even_addr_o | output | SLOT_W+X_W | Even-bank address {slot, column} |
| rd_odd_addr_o | output | SLOT_W+X_W | Odd-bank address {slot, column} |
| even_pix_i | input | NCH*CH_W | Even-bank read data, one cycle after the request |
| odd_pix_i | input | NCH*CH_W | Odd-bank read data, one cycle after the request |
| pix_o | output | NCH*CH_W | Blended pixel |
| pix_vld_o | output | 1 | pix_o is valid |

## Verification
A wrong phase value shows up at the read addresses in the first strobe of the affected line. It then persists for every later line of the frame, because the error accumulates until the next frame start. A wrong bank swap or a wrong weight shows in pix_o two cycles after the first strobe that uses it. A misaligned pipeline stage shows as a valid flag offset from the strobe, or as data from the neighbouring column. The sweep changes the step on every line and lets slots wrap, so the bench sees odd and even positions and all sixteen weights, including zero.

// File: rtl/vlb_pkg.sv
package vlb_pkg;
  localparam int FRAC_W = 4;
  localparam int ONE    = 1 << FRAC_W;
endpackage

// File: rtl/vlb_phase.sv
module vlb_phase
  import vlb_pkg::*;
#(
  parameter int INT_W = 11
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_start_i,
  input  logic                    line_start_i,
  input  logic [INT_W+FRAC_W-1:0] step_i,
  output logic [INT_W-1:0]        pos_int_o,
  output logic [FRAC_W-1:0]       pos_frac_o
);
  localparam int ACC_W = INT_W + FRAC_W;

  logic [ACC_W-1:0] nxt_q, pos_q, base;

  // frame start in the same cycle as a line start wins
  assign base = frame_start_i ? '0 : nxt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q <= '0;
      pos_q <= '0;
    end else if (line_start_i) begin
      pos_q <= base;
      nxt_q <= base + step_i;
    end else if (frame_start_i) begin
      nxt_q <= '0;
    end
  end

  assign pos_int_o  = pos_q[ACC_W-1:FRAC_W];
  assign pos_frac_o = pos_q[FRAC_W-1:0];
endmodule

// File: rtl/vlb_addr.sv
module vlb_addr #(
  parameter int X_W    = 10,
  parameter int SLOT_W = 3,
  parameter int INT_W  = 11
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  line_start_i,
  input  logic                  pix_stb_i,
  input  logic [INT_W-1:0]      pos_int_i,
  output logic [SLOT_W+X_W-1:0] even_addr_o,
  output logic [SLOT_W+X_W-1:0] odd_addr_o,
  output logic                  swap_o
);
  logic [X_W-1:0]    x_q;
  logic [INT_W:0]    pos_inc;
  logic [SLOT_W-1:0] even_slot, odd_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           x_q <= '0;
    else if (line_start_i) x_q <= '0;
    else if (pix_stb_i)    x_q <= x_q + 1'b1;
  end

  // even line of the pair is n (n even) or n+1 (n odd)
  assign pos_inc   = {1'b0, pos_int_i} + 1'b1;
  assign even_slot = pos_inc[SLOT_W:1];
  assign odd_slot  = pos_int_i[SLOT_W:1];
  assign swap_o    = pos_int_i[0];

  assign even_addr_o = {even_slot, x_q};
  assign odd_addr_o  = {odd_slot, x_q};
endmodule

// File: rtl/vlb_mix.sv
module vlb_mix
  import vlb_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int CH_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pix_stb_i,
  input  logic                  swap_i,
  input  logic [FRAC_W-1:0]     w_i,
  input  logic [NCH*CH_W-1:0]   even_pix_i,
  input  logic [NCH*CH_W-1:0]   odd_pix_i,
  output logic [NCH*CH_W-1:0]   pix_o,
  output logic                  pix_vld_o
);
  localparam int SUM_W = CH_W + FRAC_W + 1;

  // stage 1 aligns control with the memory latency
  logic              vld1_q, swap1_q;
  logic [FRAC_W-1:0] w1_q;
  logic [NCH*CH_W-1:0] mix;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld1_q  <= 1'b0;
      swap1_q <= 1'b0;
      w1_q    <= '0;
    end else begin
      vld1_q <= pix_stb_i;
      if (pix_stb_i) begin
        swap1_q <= swap_i;
        w1_q    <= w_i;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CH_W-1:0]   a, b;
    logic [SUM_W-1:0]  wa, wb, sum;
    assign a   = swap1_q ? odd_pix_i[c*CH_W +: CH_W]  : even_pix_i[c*CH_W +: CH_W];
    assign b   = swap1_q ? even_pix_i[c*CH_W +: CH_W] : odd_pix_i[c*CH_W +: CH_W];
    assign wa  = SUM_W'(a) * SUM_W'(ONE - {1'b0, w1_q});
    assign wb  = SUM_W'(b) * SUM_W'(w1_q);
    assign sum = wa + wb + SUM_W'(ONE / 2);
    assign mix[c*CH_W +: CH_W] = sum[FRAC_W +: CH_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o     <= '0;
      pix_vld_o <= 1'b0;
    end else begin
      pix_vld_o <= vld1_q;
      if (vld1_q) pix_o <= mix;
    end
  end
endmodule

// File: rtl/vlb_blender.sv
module vlb_blender
  import vlb_pkg::*;
#(
  parameter int X_W    = 10,
  parameter int SLOT_W = 3,
  parameter int INT_W  = 11,
  parameter int NCH    = 3,
  parameter int CH_W   = 8,
  localparam int ADDR_W = SLOT_W + X_W,
  localparam int STEP_W = INT_W + FRAC_W,
  localparam int PIX_W  = NCH * CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              line_start_i,
  input  logic              pix_stb_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_even_addr_o,
  output logic [ADDR_W-1:0] rd_odd_addr_o,
  input  logic [PIX_W-1:0]  even_pix_i,
  input  logic [PIX_W-1:0]  odd_pix_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              pix_vld_o
);
  logic [INT_W-1:0]  pos_int;
  logic [FRAC_W-1:0] pos_frac;
  logic              swap;

  vlb_phase #(.INT_W(INT_W)) u_phase (
    .clk_i, .rst_ni, .frame_start_i, .line_start_i, .step_i,
    .pos_int_o(pos_int), .pos_frac_o(pos_frac)
  );

  vlb_addr #(.X_W(X_W), .SLOT_W(SLOT_W), .INT_W(INT_W)) u_addr (
    .clk_i, .rst_ni, .line_start_i, .pix_stb_i,
    .pos_int_i(pos_int),
    .even_addr_o(rd_even_addr_o), .odd_addr_o(rd_odd_addr_o), .swap_o(swap)
  );

  vlb_mix #(.NCH(NCH), .CH_W(CH_W)) u_mix (
    .clk_i, .rst_ni, .pix_stb_i, .swap_i(swap), .w_i(pos_frac),
    .even_pix_i, .odd_pix_i, .pix_o, .pix_vld_o
  );

  assign rd_en_o = pix_stb_i;
endmodule

// File: rtl/vlb_blender_chk.sv
module vlb_blender_chk #(
  parameter int X_W    = 10,
  parameter int SLOT_W = 3,
  parameter int NCH    = 3,
  parameter int CH_W   = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  line_start_i,
  input logic                  pix_stb_i,
  input logic                  rd_en_o,
  input logic [SLOT_W+X_W-1:0] rd_even_addr_o,
  input logic [SLOT_W+X_W-1:0] rd_odd_addr_o,
  input logic [NCH*CH_W-1:0]   pix_o,
  input logic                  pix_vld_o
);
  logic [SLOT_W-1:0] es, os, sd;
  logic [X_W-1:0]    ex, ox;
  assign es = rd_even_addr_o[SLOT_W+X_W-1:X_W];
  assign os = rd_odd_addr_o[SLOT_W+X_W-1:X_W];
  assign ex = rd_even_addr_o[X_W-1:0];
  assign ox = rd_odd_addr_o[X_W-1:0];
  assign sd = es - os;

  always_comb begin
    if (!rst_ni) AST_RESET_QUIET: assert (!pix_vld_o && pix_o == '0); // R1
  end

  AST_VLD_AFTER_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_stb_i |=> ##1 pix_vld_o); // R9
  AST_VLD_NEEDS_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_o |-> $past(pix_stb_i, 2)); // R9
  AST_PIX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_vld_o |-> $stable(pix_o)); // R9
  AST_RD_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o == pix_stb_i); // R2
  AST_COL_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex == ox); // R3
  AST_COL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_stb_i && !line_start_i |=> ex == $past(ex) + 1'b1); // R3
  AST_COL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_stb_i && !line_start_i |=> $stable(ex)); // R3
  AST_SLOT_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd == '0 || sd == SLOT_W'(1)); // R5
  AST_SLOT_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(es) && $stable(os)); // R4
endmodule

bind vlb_blender vlb_blender_chk #(.X_W(X_W), .SLOT_W(SLOT_W), .NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i), .pix_stb_i(pix_stb_i),
  .rd_en_o(rd_en_o), .rd_even_addr_o(rd_even_addr_o), .rd_odd_addr_o(rd_odd_addr_o),
  .pix_o(pix_o), .pix_vld_o(pix_vld_o)
);

// File: tb/tb_vlb_blender.sv
module tb_vlb_blender;
  localparam int X_W = 3, SLOT_W = 2, INT_W = 6, NCH = 2, CH_W = 8;
  localparam int AW = SLOT_W + X_W, SW = INT_W + 4, PW = NCH * CH_W;

  logic clk = 0, rst_n = 0;
  logic fs = 0, ls = 0, stb = 0;
  logic [SW-1:0] step = '0;
  logic rd_en, vld;
  logic [AW-1:0] ea, oa;
  logic [PW-1:0] even_q = '0, odd_q = '0, pix;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_nxt = 0, m_pos = 0, m_x = 0;
  logic        d1_v = 0, d2_v = 0;
  logic [PW-1:0] d1_p = '0, d2_p = '0;

  always #10 clk = ~clk;

  vlb_blender #(.X_W(X_W), .SLOT_W(SLOT_W), .INT_W(INT_W), .NCH(NCH), .CH_W(CH_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .line_start_i(ls), .pix_stb_i(stb),
    .step_i(step), .rd_en_o(rd_en), .rd_even_addr_o(ea), .rd_odd_addr_o(oa),
    .even_pix_i(even_q), .odd_pix_i(odd_q), .pix_o(pix), .pix_vld_o(vld)
  );

  function automatic logic [CH_W-1:0] pat(int addr, int bank, int c);
    return CH_W'((addr * 37 + bank * 101 + c * 59 + 13) * (addr[0] ? 7 : 1));
  endfunction

  function automatic logic [PW-1:0] row(int addr, int bank);
    logic [PW-1:0] r;
    for (int c = 0; c < NCH; c++) r[c*CH_W +: CH_W] = pat(addr, bank, c);
    return r;
  endfunction

  always @(posedge clk) if (rd_en) begin
    even_q <= row(int'(ea), 0);
    odd_q  <= row(int'(oa), 1);
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(bit f, bit l, bit s, int st);
    logic [PW-1:0] e;
    int n, w, es, os, eadr, oadr;
    @(negedge clk);
    chk(vld == d2_v, "R9 valid", vld, d2_v);
    if (d2_v) chk(pix == d2_p, "R6/R7/R8/R10 pixel", pix, d2_p);
    fs = f; ls = l; stb = s; step = SW'(st);
    #1;
    chk(rd_en == s, "R2 rd_en", rd_en, s);
    e = '0;
    if (s) begin
      n = m_pos >> 4; w = m_pos & 15;
      es = ((n + 1) >> 1) % (1 << SLOT_W); os = (n >> 1) % (1 << SLOT_W);
      eadr = es * (1 << X_W) + m_x; oadr = os * (1 << X_W) + m_x;
      chk(int'(ea) == eadr, "R3/R4/R5 even addr", ea, eadr);
      chk(int'(oa) == oadr, "R3/R4/R5 odd addr", oa, oadr);
      for (int c = 0; c < NCH; c++) begin
        int a, b;
        a = (n % 2 == 1) ? pat(oadr, 1, c) : pat(eadr, 0, c);
        b = (n % 2 == 1) ? pat(eadr, 0, c) : pat(oadr, 1, c);
        e[c*CH_W +: CH_W] = CH_W'((a * (16 - w) + b * w + 8) >> 4);
        if (w == 0) chk(e[c*CH_W +: CH_W] == CH_W'(a), "R8 zero weight", e[c*CH_W +: CH_W], a);
      end
    end
    d2_v = d1_v; d2_p = d1_p; d1_v = s; d1_p = e;
    if (l) begin
      m_pos = f ? 0 : m_nxt;
      m_nxt = (m_pos + st) % (1 << SW);
      m_x = 0;
    end else begin
      if (f) m_nxt = 0;
      if (s) m_x = (m_x + 1) % (1 << X_W);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(vld == 0, "R1 reset valid", vld, 0);
    chk(pix == '0, "R1 reset pixel", pix, 0);
    rst_n = 1;
    for (int f = 0; f < 8; f++) begin
      for (int l = 0; l < 12; l++) begin
        int st;
        st = (f == 3) ? 16 : (f * 7 + l * 5 + 3) % 33;
        cyc(l == 0, 1, 0, st);
        for (int i = 0; i < (1 << X_W); i++) begin
          if ((i + f + l) % 3 == 2) cyc(0, 0, 0, 0);
          cyc(0, 0, 1, 0);
        end
        if (l == 5) cyc(1, 0, 0, 0); // lone frame start resets the phase (R4)
      end
    end
    repeat (3) cyc(0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule